// File: doc/BRIEF.md
# Prioritized Status LED Pattern Generator

This block drives a single status LED from four module health inputs: an external reset request, a combined power-sense flag, a power-good line and an FPGA configuration-done flag. It picks the most urgent active condition and plays that condition's eight-slot on/off pattern, over and over. Each slot lasts a fixed number of system clocks, and that number is derived from two parameters, the clock rate and the slot rate. The defaults give six slots per second. The reset pattern toggles on every slot, so it blinks at about 3 Hz.

When no condition is active, the module is ready and configured. In that state the LED simply mirrors a pass-through input that the FPGA drives. All board inputs, including the pass-through, go through a multi-flop synchronizer before any decision is made. Whenever the winning condition changes, the pattern restarts from its first slot.

Top module: `led_prio_pattern`

## Requirements
- R1: While `rst_n_i` is low, `led_o` is low.
- R2: A low `rst_req_n_i` wins over every other input. The LED is on in even slots (0, 2, 4, 6) and off in odd slots.
- R3: When `pwr_fail_n_i` is low and no reset request is active, the LED is on in slots 0 to 4 and off in slots 5 to 7.
- R4: When `pgood_fail_n_i` is low and neither condition above is active, the LED is on in slots 0 to 3 and off in slots 4 to 7.
- R5: When `cfg_done_i` is low (not configured) and no condition above is active, the LED is on in slot 0 only.
- R6: When no condition is active, `led_o` equals `fpga_led_i` as it was two clock edges earlier.
- R7: Each slot lasts DIV = CLK_HZ/SLOT_HZ clocks. After slot 7 the sequence wraps to slot 0.
- R8: A change of the winning condition takes effect on the third clock edge after the input change, and the sequence then starts at slot 0.
- R9: Changes on lower-ranked inputs while a higher-ranked condition is active leave the running sequence undisturbed.
- R10: `fpga_led_i` has no effect on `led_o` while any condition is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| rst_req_n_i | input | 1 | External reset request, active low |
| pwr_fail_n_i | input | 1 | Combined power-sense flag, low means a failure |
| pgood_fail_n_i | input | 1 | Sensed power-good line, low means power not good |
| cfg_done_i | input | 1 | FPGA configuration done, high when configured |
| fpga_led_i | input | 1 | FPGA-driven LED value used when idle |
| led_o | output | 1 | Status LED drive, high means on |

## Verification
The ranking and pass-through assertions compare the selected condition with port values three or two edges in the past. They therefore assume that the inputs are stable, ordinary logic levels and that `fpga_led_i` is low while reset is held. The synchronizer reset value must not disagree with the sampled history. The stimulus drives every input only on the falling clock edge and keeps the pass-through low during reset. It holds each input combination long enough for a condition to settle past the synchronizer before any comparison is made. Before each combination it steps through a different winning condition, so every sequence under test starts from a known restart.

// File: rtl/led_status_pkg.sv
// Package: shared condition codes and slot patterns for the status LED block.
// Assumes an 8-slot sequence; bit i of a pattern is the LED value in slot i.
package led_status_pkg;

    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    // Condition codes, lower value = higher priority.
    typedef enum logic [2:0] {
        COND_RESET = 3'd0,
        COND_PWR   = 3'd1,
        COND_PGOOD = 3'd2,
        COND_UNCFG = 3'd3,
        COND_IDLE  = 3'd4
    } cond_e;

    localparam logic [SLOTS-1:0] PAT_RESET = 8'b0101_0101;
    localparam logic [SLOTS-1:0] PAT_PWR   = 8'b0001_1111;
    localparam logic [SLOTS-1:0] PAT_PGOOD = 8'b0000_1111;
    localparam logic [SLOTS-1:0] PAT_UNCFG = 8'b0000_0001;

    // Map a condition to its slot pattern; idle has none (all zero).
    function automatic logic [SLOTS-1:0] pattern_of(cond_e c);
        case (c)
            COND_RESET: return PAT_RESET;
            COND_PWR:   return PAT_PWR;
            COND_PGOOD: return PAT_PGOOD;
            COND_UNCFG: return PAT_UNCFG;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/led_sync.sv
// Module: multi-stage synchronizer for a bus of independent board inputs.
// Assumes each bit is an unrelated level signal; no bus coherency implied.
// RESET_VAL sets each bit's value during reset (chosen as the idle level).
module led_sync #(
    parameter int             W         = 5,
    parameter int             STAGES    = 2,
    parameter logic [W-1:0]   RESET_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the inputs through STAGES flops.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/led_prio_select.sv
// Module: fixed-priority selector of the active health condition.
// Assumes synchronized inputs; reset request, power-sense and power-good are
// active low, configuration-done is active high.
module led_prio_select
    import led_status_pkg::*;
(
    input  logic  rst_req_n_i,
    input  logic  pwr_fail_n_i,
    input  logic  pgood_fail_n_i,
    input  logic  cfg_done_i,
    output cond_e cond_o
);

    // Pick the highest-ranked active condition, idle if none.
    always_comb begin
        if (!rst_req_n_i)        cond_o = COND_RESET;
        else if (!pwr_fail_n_i)   cond_o = COND_PWR;
        else if (!pgood_fail_n_i) cond_o = COND_PGOOD;
        else if (!cfg_done_i)     cond_o = COND_UNCFG;
        else                      cond_o = COND_IDLE;
    end

endmodule

// File: rtl/led_slot_timer.sv
// Module: prescaler plus slot counter for the LED pattern sequencer.
// Produces a slot index that advances every DIV clocks and wraps after the
// last slot. restart_i clears both counters in the same cycle.
module led_slot_timer #(
    parameter int DIV    = 4,
    parameter int SLOT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              restart_i,
    output logic              tick_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0]     presc_q;
    logic [SLOT_W-1:0] slot_q;

    assign tick_o = (presc_q == LAST);
    assign slot_o = slot_q;

    // Count clocks within a slot and step the slot on the last one.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            presc_q <= '0;
            slot_q  <= '0;
        end else if (restart_i) begin
            presc_q <= '0;
            slot_q  <= '0;
        end else if (tick_o) begin
            presc_q <= '0;
            slot_q  <= slot_q + 1'b1;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

endmodule

// File: rtl/led_prio_pattern.sv
// Module: top of the prioritized status LED pattern generator.
// Synchronizes the board inputs, selects the winning condition, restarts the
// slot sequence on every change of winner and plays that condition's pattern.
// When idle, the LED mirrors the synchronized FPGA pass-through.
// Assumes CLK_HZ >= SLOT_HZ; a quotient below one is treated as one.
module led_prio_pattern
    import led_status_pkg::*;
#(
    parameter int CLK_HZ      = 25_000_000,
    parameter int SLOT_HZ     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic rst_req_n_i,
    input  logic pwr_fail_n_i,
    input  logic pgood_fail_n_i,
    input  logic cfg_done_i,
    input  logic fpga_led_i,
    output logic led_o
);

    localparam int DIV = (CLK_HZ / SLOT_HZ < 1) ? 1 : CLK_HZ / SLOT_HZ;
    localparam int NIN = 5;
    // Bit order: {fpga_led, cfg_done, pgood_fail_n, pwr_fail_n, rst_req_n}.
    localparam logic [NIN-1:0] SYNC_IDLE = 5'b01111;

    logic [NIN-1:0]    raw_in;
    logic [NIN-1:0]    sync_in;
    cond_e             cond_sel;
    cond_e             cond_q;
    logic              cond_chg;
    logic              slot_tick;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOTS-1:0]  cur_pat;
    logic              pass_s;

    assign raw_in = {fpga_led_i, cfg_done_i, pgood_fail_n_i, pwr_fail_n_i, rst_req_n_i};

    led_sync #(
        .W         (NIN),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SYNC_IDLE)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (raw_in),
        .q_o     (sync_in)
    );

    led_prio_select sel_i (
        .rst_req_n_i    (sync_in[0]),
        .pwr_fail_n_i   (sync_in[1]),
        .pgood_fail_n_i (sync_in[2]),
        .cfg_done_i     (sync_in[3]),
        .cond_o         (cond_sel)
    );

    assign pass_s   = sync_in[4];
    assign cond_chg = (cond_sel != cond_q);

    // Register the winning condition; a difference marks a restart.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) cond_q <= COND_IDLE;
        else          cond_q <= cond_sel;
    end

    led_slot_timer #(
        .DIV    (DIV),
        .SLOT_W (SLOT_W)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .restart_i (cond_chg),
        .tick_o    (slot_tick),
        .slot_o    (slot_q)
    );

    // Look up the pattern and mux in the pass-through when idle.
    always_comb begin
        cur_pat = pattern_of(cond_q);
        if (cond_q == COND_IDLE) led_o = pass_s;
        else                     led_o = cur_pat[slot_q];
    end

endmodule

// File: rtl/led_prio_pattern_chk.sv
// Checker: temporal properties of the status LED block, bound to its top.
// Assumes fpga_led_i is low while reset is held (matches synchronizer reset).
module led_prio_pattern_chk
    import led_status_pkg::*;
(
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       rst_req_n_i,
    input logic       pwr_fail_n_i,
    input logic       fpga_led_i,
    input logic       led_o,
    input logic [2:0] cond_sel,
    input logic [2:0] cond_q,
    input logic       slot_tick,
    input logic [2:0] slot_q
);

    logic [1:0] since_rst;

    // Count edges since reset release, saturating, to guard $past depth.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cond_sel != cond_q) |=> (slot_q == 3'd0));

    assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!slot_tick && cond_sel == cond_q) |=> $stable(slot_q));

    assert_slot_step_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (slot_tick && cond_sel == cond_q) |=> (slot_q == $past(slot_q) + 3'd1));

    assert_reset_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (since_rst == 2'd3 && !$past(rst_req_n_i, 3)) |-> (cond_q == COND_RESET));

    assert_power_rank_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (since_rst == 2'd3 && $past(rst_req_n_i, 3) && !$past(pwr_fail_n_i, 3))
        |-> (cond_q == COND_PWR));

    assert_idle_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (since_rst >= 2'd2 && cond_q == COND_IDLE) |-> (led_o == $past(fpga_led_i, 2)));

    assert_uncfg_dark_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cond_q == COND_UNCFG && slot_q != 3'd0) |-> !led_o);

endmodule

bind led_prio_pattern led_prio_pattern_chk chk_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_req_n_i  (rst_req_n_i),
    .pwr_fail_n_i (pwr_fail_n_i),
    .fpga_led_i   (fpga_led_i),
    .led_o        (led_o),
    .cond_sel     (cond_sel),
    .cond_q       (cond_q),
    .slot_tick    (slot_tick),
    .slot_q       (slot_q)
);

// File: tb/led_prio_pattern_tb_top.sv
// Bench: near-exhaustive sweep of all input combinations on a small divider.
module led_prio_pattern_tb_top;

    localparam int CLK_HZ  = 32;
    localparam int SLOT_HZ = 8;
    localparam int DIV     = CLK_HZ / SLOT_HZ;

    logic clk = 1'b0;
    logic rst_n, rq_n, pf_n, pg_n, done, pass;
    wire  led;
    int   n_checks = 0;
    int   n_fails  = 0;

    always #4ns clk = ~clk;

    led_prio_pattern #(.CLK_HZ(CLK_HZ), .SLOT_HZ(SLOT_HZ), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .rst_req_n_i(rq_n), .pwr_fail_n_i(pf_n),
        .pgood_fail_n_i(pg_n), .cfg_done_i(done), .fpga_led_i(pass), .led_o(led)
    );

    // Expected winner: 0 reset, 1 power, 2 power-good, 3 unconfigured, 4 idle.
    function automatic int exp_cond(int v);
        if (!v[0]) return 0;
        if (!v[1]) return 1;
        if (!v[2]) return 2;
        if (!v[3]) return 3;
        return 4;
    endfunction

    function automatic logic exp_led(int v, int slot);
        case (exp_cond(v))
            0: return (slot % 2) == 0;
            1: return slot < 5;
            2: return slot < 4;
            3: return slot == 0;
            default: return v[4];
        endcase
    endfunction

    task automatic check(logic got, logic exp, string req, int info);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s (case %0d): led_o=%0b expected %0b", req, info, got, exp);
        end
    endtask

    task automatic drive(int v);
        rq_n = v[0]; pf_n = v[1]; pg_n = v[2]; done = v[3]; pass = v[4];
    endtask

    function automatic string req_of(int v);
        case (exp_cond(v))
            0: return "R2/R7/R10";
            1: return "R3/R7/R10";
            2: return "R4/R7/R10";
            3: return "R5/R7/R10";
            default: return "R6";
        endcase
    endfunction

    // Bring in a different winner first, then the case under test (R8 restart).
    task automatic run_combo(int v, bit lower_flip);
        @(negedge clk);
        if (exp_cond(v) != 0) drive(v & ~1);
        else                  drive(5'b01111);
        repeat (4) @(posedge clk);
        @(negedge clk);
        drive(v);
        repeat (3) @(posedge clk);
        for (int c = 0; c < 9 * DIV; c++) begin
            @(negedge clk);
            check(led, exp_led(v, (c / DIV) % 8), lower_flip ? "R9" : req_of(v), v);
            if (lower_flip && c == 10) begin
                pg_n = 1'b0; done = 1'b0; pf_n = 1'b0;
            end
            @(posedge clk);
        end
    endtask

    initial begin
        #2ms;
        n_fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(0);
        pass = 1'b0;
        // R1: all conditions active but block held in reset.
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(led, 1'b0, "R1", k);
            @(posedge clk);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep every combination of the five inputs (R2-R5, R7, R8, R10, R6).
        for (int v = 0; v < 32; v++) run_combo(v, 1'b0);

        // R9: reset request active; lower inputs change mid-sequence.
        run_combo(5'b01110, 1'b1);

        // R6: idle pass-through follows with two-edge latency.
        @(negedge clk);
        drive(5'b01111);
        repeat (4) @(posedge clk);
        for (int k = 0; k < 8; k++) begin
            logic prev;
            @(negedge clk);
            prev = pass;
            pass = ~pass;
            @(posedge clk);
            @(negedge clk);
            check(led, prev, "R6", k);
            @(posedge clk);
            @(negedge clk);
            check(led, ~prev, "R6", k);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule